// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block produces the instruction fetch address for a small microcontroller core. It holds a 13-bit program counter and an eight-entry circular stack of return addresses. It also holds two fixed entry points: 0000h after reset and 0004h on interrupt entry. In every clock cycle, which is one instruction cycle, the counter either advances by one or takes a new value from one of the control requests. Those requests are a jump, a call, a return, a return from interrupt and an interrupt entry.

The fetch address is the low 12 bits of the program counter. Any address from 1000h up to 1FFFh therefore reads the same word as its value modulo 4096.

The interface has only plain control pins, with no data stream and no valid/ready handshake. Every request is sampled on a rising clock edge and acts on that edge. No request can be refused, so there is no back-pressure. When several requests arrive together, a fixed priority picks one of them and the others are dropped.

Top module: `iaddr_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is 0000h and `reti_flag` is 0, whatever the other inputs are. Reset also empties the stack and clears all eight entries to 0000h.
- R2: In a cycle with no request, `pc_q` advances by one on the clock edge. From 1FFFh it wraps to 0000h.
- R3: `fetch_addr` always equals `pc_q` modulo 4096, which is `pc_q[11:0]`. For example, 0420h, 0C20h and 1C20h all give fetch address 420h or C20h as their low 12 bits dictate.
- R4: A jump loads `tgt_addr` into `pc_q` on the clock edge and leaves the stack unchanged.
- R5: A call loads `tgt_addr` and pushes `pc_q`+1 (modulo 8192) onto the stack.
- R6: A return pops the top of the stack into `pc_q`. This request is used for both the plain return and the return that carries a literal.
- R7: A return from interrupt pops the stack like a return. `reti_flag` is then high for exactly the one following cycle.
- R8: An interrupt entry loads 0004h and pushes `pc_q`+1 (modulo 8192).
- R9: When requests conflict, exactly one of them takes effect, in this priority order: interrupt entry, call, jump, return, return from interrupt. The losing requests neither move the stack nor raise `reti_flag`.
- R10: The stack has eight slots and is circular. A ninth push overwrites the oldest entry without any indication. A pop of an empty stack wraps the pointer and returns whatever is stored in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_take | input | 1 | Enter the interrupt handler |
| call_req | input | 1 | Call `tgt_addr` and save the return address |
| jmp_req | input | 1 | Jump to `tgt_addr` |
| ret_req | input | 1 | Return to the saved address |
| reti_req | input | 1 | Return from interrupt |
| tgt_addr | input | 13 | Target address for jump and call |
| pc_q | output | 13 | Current program counter |
| fetch_addr | output | 12 | Address into the implemented program memory |
| reti_flag | output | 1 | One-cycle pulse after a return from interrupt |

## Verification
The hardest states to reach from the ports are the stack after overflow and after an empty pop, together with proof that a losing request left the stack alone. Neither shows on any output until later pops expose the stored entries. The stimulus makes a directed chain of nine calls followed by nine returns and an empty pop straight after reset. It then runs seeded random traffic that frequently sets several requests at once, and later pops reveal any stray push or pop.

// File: rtl/iaddr_pkg.sv
package iaddr_pkg;
  typedef enum logic [2:0] {
    ACT_SEQ  = 3'd0,
    ACT_IRQ  = 3'd1,
    ACT_CALL = 3'd2,
    ACT_JMP  = 3'd3,
    ACT_RET  = 3'd4,
    ACT_RETI = 3'd5
  } act_e;
endpackage

// File: rtl/iaddr_arb.sv
module iaddr_arb
  import iaddr_pkg::*;
(
  input  logic irq_take,
  input  logic call_req,
  input  logic jmp_req,
  input  logic ret_req,
  input  logic reti_req,
  output act_e act,
  output logic push,
  output logic pop
);
  always_comb begin
    if (irq_take)      act = ACT_IRQ;
    else if (call_req) act = ACT_CALL;
    else if (jmp_req)  act = ACT_JMP;
    else if (ret_req)  act = ACT_RET;
    else if (reti_req) act = ACT_RETI;
    else               act = ACT_SEQ;
  end

  assign push = (act == ACT_IRQ) || (act == ACT_CALL);
  assign pop  = (act == ACT_RET) || (act == ACT_RETI);

  // R9: a lower-priority request never wins over a higher one
  always_comb begin
    if (irq_take) assert (act == ACT_IRQ) else $error("p_irq_wins_r9");
    if (!irq_take && call_req) assert (act == ACT_CALL) else $error("p_call_wins_r9");
    assert (!(push && pop)) else $error("p_push_pop_excl_r9");
  end
endmodule

// File: rtl/iaddr_retstack.sv
module iaddr_retstack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptr_inc, ptr_dec;
  logic [W-1:0]     slot [DEPTH];

  assign ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign ptr_dec = (ptr == '0) ? LAST : ptr - 1'b1;
  assign top     = slot[ptr_dec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (push) ptr <= ptr_inc;
    else if (pop)  ptr <= ptr_dec;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[i] <= '0;
      else if (push && ptr == PTR_W'(i)) slot[i] <= wdata;
    end
  end

  // R10: pointer moves one slot per push or pop and wraps around
  p_push_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
  p_pop_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> ptr == (($past(ptr) == '0) ? LAST : $past(ptr) - 1'b1));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(ptr));
endmodule

// File: rtl/iaddr_unit.sv
module iaddr_unit
  import iaddr_pkg::*;
#(
  parameter int          PC_W    = 13,
  parameter int          MEM_W   = 12,
  parameter int          DEPTH   = 8,
  parameter logic [12:0] RST_VEC = 13'h0000,
  parameter logic [12:0] IRQ_VEC = 13'h0004
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_take,
  input  logic             call_req,
  input  logic             jmp_req,
  input  logic             ret_req,
  input  logic             reti_req,
  input  logic [PC_W-1:0]  tgt_addr,
  output logic [PC_W-1:0]  pc_q,
  output logic [MEM_W-1:0] fetch_addr,
  output logic             reti_flag
);
  localparam logic [PC_W-1:0] RST_PC = PC_W'(RST_VEC);
  localparam logic [PC_W-1:0] IRQ_PC = PC_W'(IRQ_VEC);

  act_e            act;
  logic            push, pop;
  logic [PC_W-1:0] pc_inc, pc_nxt, stk_top;

  iaddr_arb u_arb (
    .irq_take (irq_take),
    .call_req (call_req),
    .jmp_req  (jmp_req),
    .ret_req  (ret_req),
    .reti_req (reti_req),
    .act      (act),
    .push     (push),
    .pop      (pop)
  );

  assign pc_inc = pc_q + 1'b1;

  iaddr_retstack #(.W(PC_W), .DEPTH(DEPTH)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (pc_inc),
    .top   (stk_top)
  );

  always_comb begin
    unique case (act)
      ACT_IRQ:            pc_nxt = IRQ_PC;
      ACT_CALL, ACT_JMP:  pc_nxt = tgt_addr;
      ACT_RET, ACT_RETI:  pc_nxt = stk_top;
      default:            pc_nxt = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= RST_PC;
      reti_flag <= 1'b0;
    end else begin
      pc_q      <= pc_nxt;
      reti_flag <= (act == ACT_RETI);
    end
  end

  if (MEM_W < PC_W) begin : g_alias
    assign fetch_addr = pc_q[MEM_W-1:0];
  end else begin : g_full
    assign fetch_addr = MEM_W'(pc_q);
  end

  // R1: reset holds the entry point
  always @(posedge clk) begin
    if (!rst_n) assert (pc_q == RST_PC && !reti_flag) else $error("p_reset_vec_r1");
  end
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && !call_req && !jmp_req && !ret_req && !reti_req)
      |=> pc_q == PC_W'($past(pc_q) + 1'b1));
  p_jmp_tgt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_req && !irq_take && !call_req) |=> pc_q == $past(tgt_addr));
  p_call_tgt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !irq_take) |=> pc_q == $past(tgt_addr));
  p_reti_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reti_flag |-> $past(reti_req && !irq_take && !call_req && !jmp_req && !ret_req));
  p_irq_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> pc_q == IRQ_PC);
endmodule

// File: tb/iaddr_unit_tb_top.sv
`timescale 1ns/1ps
module iaddr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_take = 0, call_req = 0, jmp_req = 0, ret_req = 0, reti_req = 0;
  logic [12:0] tgt_addr = '0;
  logic [12:0] pc_q;
  logic [11:0] fetch_addr;
  logic        reti_flag;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [12:0] m_pc;
  logic [12:0] m_stk [8];
  int          m_ptr;
  bit          m_flag;

  always #2.5 clk = ~clk;

  iaddr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .call_req(call_req),
    .jmp_req(jmp_req), .ret_req(ret_req), .reti_req(reti_req),
    .tgt_addr(tgt_addr), .pc_q(pc_q), .fetch_addr(fetch_addr), .reti_flag(reti_flag)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] inc13(logic [12:0] v);
    return v + 13'd1;
  endfunction

  task automatic do_reset(bit with_irq);
    @(negedge clk);
    rst_n = 0; irq_take = with_irq; call_req = with_irq; jmp_req = 0; ret_req = 0; reti_req = 0;
    repeat (2) @(negedge clk);
    chk(pc_q == 13'h0000, "R1 pc under reset", pc_q, 0);
    chk(reti_flag == 1'b0, "R1 flag under reset", reti_flag, 0);
    m_pc = 0; m_ptr = 0; m_flag = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    irq_take = 0; call_req = 0;
    rst_n = 1;
  endtask

  // drive one instruction cycle, update model, compare after the edge
  task automatic step(bit i, bit c, bit j, bit r, bit ri, logic [12:0] t);
    string tag;
    int nreq;
    irq_take = i; call_req = c; jmp_req = j; ret_req = r; reti_req = ri; tgt_addr = t;
    nreq = int'(i) + int'(c) + int'(j) + int'(r) + int'(ri);
    m_flag = 0;
    if (i) begin
      tag = "R8 irq";
      m_stk[m_ptr] = inc13(m_pc); m_ptr = (m_ptr + 1) % 8; m_pc = 13'h0004;
    end else if (c) begin
      tag = "R5 call";
      m_stk[m_ptr] = inc13(m_pc); m_ptr = (m_ptr + 1) % 8; m_pc = t;
    end else if (j) begin
      tag = "R4 jump";
      m_pc = t;
    end else if (r) begin
      tag = "R6 return";
      m_ptr = (m_ptr + 7) % 8; m_pc = m_stk[m_ptr];
    end else if (ri) begin
      tag = "R7 reti";
      m_ptr = (m_ptr + 7) % 8; m_pc = m_stk[m_ptr]; m_flag = 1;
    end else begin
      tag = "R2 sequential";
      m_pc = inc13(m_pc);
    end
    if (nreq > 1) tag = {"R9 priority ", tag};
    @(posedge clk);
    @(negedge clk);
    chk(pc_q == m_pc, tag, pc_q, m_pc);
    chk(fetch_addr == m_pc[11:0], "R3 fetch alias", fetch_addr, m_pc[11:0]);
    chk(reti_flag == m_flag, "R7 flag", reti_flag, m_flag);
    irq_take = 0; call_req = 0; jmp_req = 0; ret_req = 0; reti_req = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset wins over interrupt and call
    do_reset(1'b1);
    step(0,0,0,0,0,'0);               // R2
    step(0,0,0,1,0,'0);               // R10 empty pop returns cleared slot 7
    step(0,0,1,0,0,13'h1FFF);         // R4
    step(0,0,0,0,0,'0);               // R2 wrap to 0000h
    chk(pc_q == 13'h0000, "R2 wrap", pc_q, 0);
    step(0,0,1,0,0,13'h1C20);         // R3 alias
    chk(fetch_addr == 12'hC20, "R3 1C20 alias", fetch_addr, 12'hC20);
    step(0,0,1,0,0,13'h0420);
    chk(fetch_addr == 12'h420, "R3 0420 fetch", fetch_addr, 12'h420);
    step(0,0,1,0,0,13'h1FFF);
    step(0,1,0,0,0,13'h0100);         // R5 pushes 0000h (wrap)
    step(0,0,0,1,0,'0);
    chk(pc_q == 13'h0000, "R5 wrapped return address", pc_q, 0);
    do_reset(1'b0);
    for (int k = 0; k < 9; k++) step(0,1,0,0,0,13'(16'h0200 + k * 16)); // R10 overflow
    for (int k = 0; k < 9; k++) step(0,0,0,1,0,'0);
    step(1,1,1,1,1,13'h0777);         // R9 irq wins
    chk(pc_q == 13'h0004, "R8 vector", pc_q, 13'h0004);
    step(0,0,1,1,1,13'h0555);         // R9 jump wins, no pop
    step(0,0,0,0,1,'0);               // R7
    step(0,0,0,0,0,'0);               // R7 flag drops
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 3) step(0,0,0,0,0,'0);
      else step($urandom_range(0,7) == 0, $urandom_range(0,3) == 0, $urandom_range(0,3) == 0,
                $urandom_range(0,2) == 0, $urandom_range(0,3) == 0, 13'($urandom));
      if (n == 2000) do_reset(1'b1);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule